// File: doc/BRIEF.md
# SCSI Initiator Arbitration and Selection Sequencer

This block is the initiator-side engine that wins the SCSI bus and selects a target. A one-cycle select command, taken only while the engine is idle, captures the engine's own 3-bit bus ID, the 3-bit target ID and an attention request. The engine then waits for the bus to go free and arbitrates by driving its own ID bit together with BSY. If it wins, it asserts SEL and places both ID bits on the data bus, hands BSY over to the target and checks that the target answers.

Every bus timing is a nanosecond parameter, turned into a clock-cycle count from the clock period parameter. The data bus and control outputs model open-collector drivers: a 1 pulls the line and a 0 releases it. The bus inputs show the wired-OR of all drivers, including this block's own. Status goes to a neighbouring status block through four signals. Lost arbitration, selection in progress and connected are levels. State change is a one-cycle pulse.

Top module: `scsi_select_seq`

## Requirements
- R1: After reset every output is low: data bus released, BSY, SEL and ATN released, busy low and all four status signals low.
- R2: A select command is taken only while idle. busy rises on the accepting edge, and the IDs and attention flag are captured there. A command that arrives while busy changes neither the IDs placed on the bus nor ATN.
- R3: After acceptance the engine waits for a clock edge at which BSY, SEL and RST are all low. It then waits FREE cycles (ceil(800 ns / clock period)) and drives the data bus to the one-hot value 1 << own ID (bit n is ID n) together with BSY.
- R4: ARB cycles (ceil(2400 ns / period)) after BSY is driven, a sampled SEL or any data bit above the own-ID bit means arbitration is lost. On that edge data and BSY are released and lost-arbitration is set. The engine goes back to waiting for a free bus, so BSY is driven again FREE cycles after the first free edge.
- R5: On a win, selection-in-progress rises and lost-arbitration clears on that same edge. Data bits below the own-ID bit never cause a loss.
- R6: WIN cycles (ceil(1200 ns / period)) after the win, the data bus carries the own-ID bit ORed with the target-ID bit and SEL is asserted while BSY is still held. SKEW2 cycles (ceil(20 ns / period)) later BSY is released, and ATN is asserted on the same edge if the command asked for it.
- R7: SETTLE cycles (ceil(400 ns / period)) after BSY is released, the BSY input is sampled. If it is high, then SKEW2 cycles later data and SEL are released, connected rises, state change pulses for exactly one cycle, selection-in-progress clears and busy falls.
- R8: If BSY is low at that sample, selection times out on that edge: busy falls, selection-in-progress clears, data, SEL and ATN are released and connected stays low.
- R9: A high RST input forces the idle state on the next edge. That edge releases every driven line, drops busy and clears all status levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_cmd | input | 1 | One-cycle select command |
| atn_req | input | 1 | Assert ATN during selection |
| own_id | input | 3 | This initiator's bus ID |
| dest_id | input | 3 | Target bus ID |
| bus_bsy_i | input | 1 | Sensed BSY line |
| bus_sel_i | input | 1 | Sensed SEL line |
| bus_rst_i | input | 1 | Sensed RST line |
| bus_data_i | input | 8 | Sensed data bus |
| data_o | output | 8 | Data bus drive (1 = pull) |
| bsy_o | output | 1 | BSY drive |
| sel_o | output | 1 | SEL drive |
| atn_o | output | 1 | ATN drive |
| busy | output | 1 | Sequence in progress |
| lost_arb | output | 1 | Lost-arbitration level |
| sel_in_prog | output | 1 | Selection-in-progress level |
| state_chg | output | 1 | One-cycle state-change pulse on connect |
| connected | output | 1 | Connected level |

## Verification
Each result is due at a fixed number of cycles after the event before it. busy is due one edge after the command. BSY is due FREE cycles after the first free edge. The loss or win is due ARB cycles later, SEL WIN cycles after that, and the BSY release with ATN SKEW2 cycles after SEL. The connect or timeout is due SETTLE cycles after the release, plus SKEW2 more for a connect. The bench keeps a free-running edge counter and samples every output on the falling edge. It records the edge on which each line changes and compares the gap with the count computed from the nanosecond constants, so a single-cycle slip in any delay shows up as a miscompare.

// File: rtl/sel_seq_pkg.sv
`timescale 1ns/1ps
package sel_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_FREE,
        ST_FREE_DLY,
        ST_ARB_DLY,
        ST_WIN_DLY,
        ST_SEL_DLY,
        ST_SETTLE_DLY,
        ST_RESP_DLY
    } seq_state_e;

    // Round a nanosecond interval up to whole clock cycles (at least one).
    function automatic int ns_to_cycles(input int ns, input int period_ns);
        int c;
        c = (ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sel_delay_ctr.sv
`timescale 1ns/1ps
module sel_delay_ctr #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/sel_id_onehot.sv
`timescale 1ns/1ps
module sel_id_onehot #(
    parameter int ID_W = 3
) (
    input  logic [ID_W-1:0]      id,
    output logic [(1<<ID_W)-1:0] bits
);
    for (genvar g = 0; g < (1 << ID_W); g++) begin : g_bit
        assign bits[g] = (id == ID_W'(g));
    end
endmodule

// File: rtl/sel_arb_judge.sv
`timescale 1ns/1ps
module sel_arb_judge #(
    parameter int ID_W = 3
) (
    input  logic [ID_W-1:0]      own_id,
    input  logic [(1<<ID_W)-1:0] bus_data,
    input  logic                 bus_sel,
    output logic                 lost
);
    localparam int N = 1 << ID_W;
    logic [N-1:0] higher;

    // A competitor outranks us when it holds any bit above our own ID.
    for (genvar g = 0; g < N; g++) begin : g_rank
        assign higher[g] = bus_data[g] && (ID_W'(g) > own_id);
    end

    assign lost = bus_sel | (|higher);
endmodule

// File: rtl/scsi_select_seq.sv
`timescale 1ns/1ps
module scsi_select_seq
    import sel_seq_pkg::*;
#(
    parameter int ID_W      = 3,
    parameter int CLK_NS    = 4,
    parameter int FREE_NS   = 800,
    parameter int ARB_NS    = 2400,
    parameter int CLEAR_NS  = 800,
    parameter int SETTLE_NS = 400,
    parameter int SKEW_NS   = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel_cmd,
    input  logic                 atn_req,
    input  logic [ID_W-1:0]      own_id,
    input  logic [ID_W-1:0]      dest_id,
    input  logic                 bus_bsy_i,
    input  logic                 bus_sel_i,
    input  logic                 bus_rst_i,
    input  logic [(1<<ID_W)-1:0] bus_data_i,
    output logic [(1<<ID_W)-1:0] data_o,
    output logic                 bsy_o,
    output logic                 sel_o,
    output logic                 atn_o,
    output logic                 busy,
    output logic                 lost_arb,
    output logic                 sel_in_prog,
    output logic                 state_chg,
    output logic                 connected
);
    localparam int DATA_W     = 1 << ID_W;
    localparam int FREE_CYC   = ns_to_cycles(FREE_NS, CLK_NS);
    localparam int ARB_CYC    = ns_to_cycles(ARB_NS, CLK_NS);
    localparam int WIN_CYC    = ns_to_cycles(CLEAR_NS + SETTLE_NS, CLK_NS);
    localparam int SKEW2_CYC  = ns_to_cycles(2 * SKEW_NS, CLK_NS);
    localparam int SETTLE_CYC = ns_to_cycles(SETTLE_NS, CLK_NS);
    localparam int MAX_CYC    = max_of(max_of(FREE_CYC, ARB_CYC),
                                       max_of(max_of(WIN_CYC, SKEW2_CYC), SETTLE_CYC));
    localparam int CNT_W      = $clog2(MAX_CYC + 1);

    typedef struct packed {
        seq_state_e        st;
        logic [ID_W-1:0]   own;
        logic [ID_W-1:0]   dest;
        logic              atn;
        logic [DATA_W-1:0] data;
        logic              bsy;
        logic              sel;
        logic              atn_drv;
        logic              lost;
        logic              sip;
        logic              conn;
        logic              chg;
    } seq_regs_t;

    seq_regs_t         r_d, r_q;
    logic              ld;
    logic [CNT_W-1:0]  ld_val;
    logic              dly_zero;
    logic              arb_lost;
    logic [DATA_W-1:0] own_bit;
    logic [DATA_W-1:0] dest_bit;

    sel_delay_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld),
        .load_val (ld_val),
        .zero     (dly_zero)
    );

    sel_id_onehot #(.ID_W(ID_W)) u_own_dec (
        .id   (r_q.own),
        .bits (own_bit)
    );

    sel_id_onehot #(.ID_W(ID_W)) u_dest_dec (
        .id   (r_q.dest),
        .bits (dest_bit)
    );

    sel_arb_judge #(.ID_W(ID_W)) u_judge (
        .own_id   (r_q.own),
        .bus_data (bus_data_i),
        .bus_sel  (bus_sel_i),
        .lost     (arb_lost)
    );

    always_comb begin
        r_d     = r_q;
        r_d.chg = 1'b0;
        ld      = 1'b0;
        ld_val  = '0;

        if (bus_rst_i) begin
            r_d = '0;
        end else begin
            unique case (r_q.st)
                ST_IDLE: begin
                    if (sel_cmd) begin
                        r_d.st      = ST_WAIT_FREE;
                        r_d.own     = own_id;
                        r_d.dest    = dest_id;
                        r_d.atn     = atn_req;
                        r_d.conn    = 1'b0;
                        r_d.atn_drv = 1'b0;
                    end
                end
                ST_WAIT_FREE: begin
                    if (!bus_bsy_i && !bus_sel_i) begin
                        r_d.st = ST_FREE_DLY;
                        ld     = 1'b1;
                        ld_val = CNT_W'(FREE_CYC - 1);
                    end
                end
                ST_FREE_DLY: begin
                    if (dly_zero) begin
                        r_d.data = own_bit;
                        r_d.bsy  = 1'b1;
                        r_d.st   = ST_ARB_DLY;
                        ld       = 1'b1;
                        ld_val   = CNT_W'(ARB_CYC - 1);
                    end
                end
                ST_ARB_DLY: begin
                    if (dly_zero) begin
                        if (arb_lost) begin
                            r_d.data = '0;
                            r_d.bsy  = 1'b0;
                            r_d.lost = 1'b1;
                            r_d.st   = ST_WAIT_FREE;
                        end else begin
                            r_d.sip  = 1'b1;
                            r_d.lost = 1'b0;
                            r_d.st   = ST_WIN_DLY;
                            ld       = 1'b1;
                            ld_val   = CNT_W'(WIN_CYC - 1);
                        end
                    end
                end
                ST_WIN_DLY: begin
                    if (dly_zero) begin
                        r_d.data = own_bit | dest_bit;
                        r_d.sel  = 1'b1;
                        r_d.st   = ST_SEL_DLY;
                        ld       = 1'b1;
                        ld_val   = CNT_W'(SKEW2_CYC - 1);
                    end
                end
                ST_SEL_DLY: begin
                    if (dly_zero) begin
                        r_d.bsy     = 1'b0;
                        r_d.atn_drv = r_q.atn;
                        r_d.st      = ST_SETTLE_DLY;
                        ld          = 1'b1;
                        ld_val      = CNT_W'(SETTLE_CYC - 1);
                    end
                end
                ST_SETTLE_DLY: begin
                    if (dly_zero) begin
                        if (bus_bsy_i) begin
                            r_d.st = ST_RESP_DLY;
                            ld     = 1'b1;
                            ld_val = CNT_W'(SKEW2_CYC - 1);
                        end else begin
                            r_d.st      = ST_IDLE;
                            r_d.data    = '0;
                            r_d.sel     = 1'b0;
                            r_d.atn_drv = 1'b0;
                            r_d.sip     = 1'b0;
                        end
                    end
                end
                ST_RESP_DLY: begin
                    if (dly_zero) begin
                        r_d.data = '0;
                        r_d.sel  = 1'b0;
                        r_d.conn = 1'b1;
                        r_d.chg  = 1'b1;
                        r_d.sip  = 1'b0;
                        r_d.st   = ST_IDLE;
                    end
                end
                default: r_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            r_q <= '0;
        else
            r_q <= r_d;
    end

    assign data_o      = r_q.data;
    assign bsy_o       = r_q.bsy;
    assign sel_o       = r_q.sel;
    assign atn_o       = r_q.atn_drv;
    assign busy        = (r_q.st != ST_IDLE);
    assign lost_arb    = r_q.lost;
    assign sel_in_prog = r_q.sip;
    assign state_chg   = r_q.chg;
    assign connected   = r_q.conn;
endmodule

// File: rtl/sel_seq_checker.sv
`timescale 1ns/1ps
module sel_seq_checker #(
    parameter int ID_W = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sel_cmd,
    input logic                 bus_rst_i,
    input logic [(1<<ID_W)-1:0] data_o,
    input logic                 bsy_o,
    input logic                 sel_o,
    input logic                 busy,
    input logic                 lost_arb,
    input logic                 state_chg,
    input logic                 connected
);
    assert_accept_needs_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(sel_cmd));

    assert_arb_drives_one_id_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bsy_o) |-> ($countones(data_o) == 1));

    assert_loss_releases_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lost_arb) |-> (!bsy_o && data_o == '0));

    assert_sel_under_bsy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_o) |-> (bsy_o && data_o != '0 && $countones(data_o) <= 2));

    assert_chg_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        state_chg |=> !state_chg);

    assert_chg_on_connect_R7: assert property (@(posedge clk) disable iff (!rst_n)
        state_chg |-> (connected && !sel_o && !busy && data_o == '0));

    assert_drive_only_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (data_o != '0 || sel_o || bsy_o) |-> busy);

    assert_bus_reset_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst_i |=> (data_o == '0 && !bsy_o && !sel_o && !busy && !lost_arb));
endmodule

bind scsi_select_seq sel_seq_checker u_chk (.*);

// File: tb/sim_scsi_select_seq.sv
`timescale 1ns/1ps
module sim_scsi_select_seq;
    localparam int E_FREE   = (800 + 3) / 4;
    localparam int E_ARB    = (2400 + 3) / 4;
    localparam int E_WIN    = (1200 + 3) / 4;
    localparam int E_SKEW2  = (20 + 3) / 4;
    localparam int E_SETTLE = (400 + 3) / 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_cmd = 1'b0;
    logic       atn_req = 1'b0;
    logic [2:0] own_id = '0;
    logic [2:0] dest_id = '0;
    logic       bus_rst_i = 1'b0;
    logic       ext_bsy = 1'b0;
    logic       ext_sel = 1'b0;
    logic [7:0] ext_data = '0;
    logic       tgt_en = 1'b0;
    logic       tgt_bsy = 1'b0;
    logic [2:0] exp_dest = '0;

    logic [7:0] data_o;
    logic bsy_o, sel_o, atn_o, busy, lost_arb, sel_in_prog, state_chg, connected;
    logic bus_bsy_i, bus_sel_i;
    logic [7:0] bus_data_i;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    bit done = 0;

    assign bus_bsy_i  = bsy_o | ext_bsy | tgt_bsy;
    assign bus_sel_i  = sel_o | ext_sel;
    assign bus_data_i = data_o | ext_data;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Target model: answers with BSY once it sees SEL, its ID bit and BSY released.
    always @(negedge clk) begin
        if (!tgt_en)
            tgt_bsy = 1'b0;
        else if (sel_o && !bsy_o && data_o[exp_dest])
            tgt_bsy = 1'b1;
    end

    scsi_select_seq u0 (
        .clk(clk), .rst_n(rst_n), .sel_cmd(sel_cmd), .atn_req(atn_req),
        .own_id(own_id), .dest_id(dest_id), .bus_bsy_i(bus_bsy_i),
        .bus_sel_i(bus_sel_i), .bus_rst_i(bus_rst_i), .bus_data_i(bus_data_i),
        .data_o(data_o), .bsy_o(bsy_o), .sel_o(sel_o), .atn_o(atn_o),
        .busy(busy), .lost_arb(lost_arb), .sel_in_prog(sel_in_prog),
        .state_chg(state_chg), .connected(connected)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic logic sigval(input int which);
        case (which)
            0: return bsy_o;
            1: return sel_o;
            2: return sel_in_prog;
            3: return connected;
            4: return busy;
            5: return lost_arb;
            default: return atn_o;
        endcase
    endfunction

    // Wait on falling edges until the chosen output reaches lvl; report the edge count.
    task automatic wait_sig(input int which, input logic lvl, output int at);
        int n = 0;
        while (sigval(which) != lvl && n < 5000) begin
            @(negedge clk);
            n++;
        end
        at = (n < 5000) ? cyc : -1;
    endtask

    task automatic issue(input logic [2:0] own, input logic [2:0] dest,
                         input logic atn, output int acc);
        own_id = own; dest_id = dest; atn_req = atn; sel_cmd = 1'b1;
        @(negedge clk);
        sel_cmd = 1'b0;
        acc = cyc;
    endtask

    task automatic pulse_bus_reset();
        bus_rst_i = 1'b1;
        @(negedge clk);
        bus_rst_i = 1'b0;
        chk("R9 data released", data_o, 0);
        chk("R9 bsy/sel/atn released", {bsy_o, sel_o, atn_o}, 0);
        chk("R9 busy low", busy, 0);
        chk("R9 status cleared", {lost_arb, sel_in_prog, connected}, 0);
        tgt_en = 1'b0;
        ext_bsy = 1'b0; ext_sel = 1'b0; ext_data = '0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 data after reset", data_o, 0);
        chk("R1 lines after reset", {bsy_o, sel_o, atn_o, busy}, 0);
        chk("R1 status after reset", {lost_arb, sel_in_prog, state_chg, connected}, 0);
    endtask

    task automatic t_normal();
        int a, b, s, f, c;
        exp_dest = 3'd2; tgt_en = 1'b1;
        issue(3'd7, 3'd2, 1'b0, a);
        chk("R2 busy on accept", busy, 1);
        wait_sig(0, 1'b1, b);
        chk("R3 bsy after bus free delay", b, a + 1 + E_FREE);
        chk("R3 own id bit on bus", data_o, 8'h80);
        wait_sig(2, 1'b1, s);
        chk("R5 win after arb delay", s, b + E_ARB);
        chk("R5 lost clear on win", lost_arb, 0);
        wait_sig(1, 1'b1, s);
        chk("R6 sel after clear+settle", s, b + E_ARB + E_WIN);
        chk("R6 own|dest on bus", data_o, 8'h84);
        wait_sig(0, 1'b0, f);
        chk("R6 bsy release after skew", f, s + E_SKEW2);
        chk("R6 no atn when not asked", atn_o, 0);
        wait_sig(3, 1'b1, c);
        chk("R7 connect timing", c, f + E_SETTLE + E_SKEW2);
        chk("R7 state change pulse", state_chg, 1);
        chk("R7 lines released", {data_o, sel_o}, 0);
        chk("R7 busy/sip low", {busy, sel_in_prog}, 0);
        @(negedge clk);
        chk("R7 pulse one cycle", state_chg, 0);
        tgt_en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_wait_free();
        int a, r, b, f, c;
        exp_dest = 3'd0; tgt_en = 1'b1;
        ext_bsy = 1'b1;
        issue(3'd1, 3'd0, 1'b1, a);
        repeat (E_FREE + 40) @(negedge clk);
        chk("R3 no arbitration while bus busy", bsy_o, 0);
        ext_bsy = 1'b0;
        r = cyc;
        wait_sig(0, 1'b1, b);
        chk("R3 bsy after free seen", b, r + 1 + E_FREE);
        wait_sig(1, 1'b1, c);
        chk("R6 own|dest low ids", data_o, 8'h03);
        wait_sig(0, 1'b0, f);
        chk("R6 atn with bsy release", atn_o, 1);
        wait_sig(3, 1'b1, c);
        chk("R7 connect with atn", c, f + E_SETTLE + E_SKEW2);
        tgt_en = 1'b0;
        pulse_bus_reset();
    endtask

    task automatic t_lose_higher();
        int a, b, l, b2;
        ext_data = 8'h20;
        issue(3'd3, 3'd0, 1'b0, a);
        wait_sig(0, 1'b1, b);
        wait_sig(5, 1'b1, l);
        chk("R4 loss to higher id timing", l, b + E_ARB);
        chk("R4 release on loss", {bsy_o, data_o}, 0);
        chk("R4 no sip on loss", sel_in_prog, 0);
        wait_sig(0, 1'b1, b2);
        chk("R4 rearbitrate after free delay", b2, l + 1 + E_FREE);
        pulse_bus_reset();
    endtask

    task automatic t_lose_sel();
        int a, b, l;
        issue(3'd6, 3'd1, 1'b0, a);
        wait_sig(0, 1'b1, b);
        ext_sel = 1'b1;
        wait_sig(5, 1'b1, l);
        chk("R4 loss to sel timing", l, b + E_ARB);
        repeat (E_FREE + 20) @(negedge clk);
        chk("R3 waits while sel held", bsy_o, 0);
        pulse_bus_reset();
    endtask

    task automatic t_lower_timeout();
        int a, b, s, f, e;
        ext_data = 8'h02;
        issue(3'd3, 3'd5, 1'b1, a);
        wait_sig(0, 1'b1, b);
        wait_sig(2, 1'b1, s);
        chk("R5 lower id does not win", s, b + E_ARB);
        chk("R5 lost stays low", lost_arb, 0);
        ext_data = '0;
        wait_sig(0, 1'b0, f);
        wait_sig(4, 1'b0, e);
        chk("R8 timeout after settle", e, f + E_SETTLE);
        chk("R8 lines released", {data_o, sel_o, atn_o, bsy_o}, 0);
        chk("R8 sip clear, not connected", {sel_in_prog, connected, state_chg}, 0);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_ignore_busy();
        int a, b, s, f;
        exp_dest = 3'd1; tgt_en = 1'b1;
        issue(3'd6, 3'd1, 1'b0, a);
        wait_sig(0, 1'b1, b);
        own_id = 3'd0; dest_id = 3'd4; atn_req = 1'b1; sel_cmd = 1'b1;
        @(negedge clk);
        sel_cmd = 1'b0;
        wait_sig(1, 1'b1, s);
        chk("R2 ids unchanged by busy command", data_o, 8'h42);
        wait_sig(0, 1'b0, f);
        chk("R2 atn unchanged by busy command", atn_o, 0);
        wait_sig(3, 1'b1, f);
        tgt_en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset_mid();
        int a, s;
        issue(3'd5, 3'd0, 1'b1, a);
        wait_sig(1, 1'b1, s);
        chk("R9 selecting before reset", sel_o, 1);
        pulse_bus_reset();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_normal();
        t_wait_free();
        t_lose_higher();
        t_lose_sel();
        t_lower_timeout();
        t_ignore_busy();
        t_reset_mid();
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 150000);
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule